// File: doc/BRIEF.md
# SPI Flash Dual-Output Read Engine

This block is an SPI master that carries out one kind of flash access: the fast read with dual-output data. On a start pulse it lowers chip select and shifts out the read opcode 0x3B. The flash address follows, then eight dummy clocks. All of this uses IO0 alone. For the dummy clocks the engine releases both IO lines. In the data phase its receiver takes two bits per SCLK rising edge, one from IO0 and one from IO1. Chip select stays low from the first opcode bit to the last data bit.

Received bytes pass through a small receive FIFO and leave on an 8-bit valid/ready stream. The rules for back-pressure are as follows. A byte transfers on every clock edge where `rx_valid` and `rx_ready` are both high. While `rx_ready` is low, `rx_data` holds still. If the FIFO is full when a new byte is about to start, SCLK is held low, so the flash keeps its data and nothing is lost. The flash is clocked in SPI mode 0 at a fixed ratio: each SCLK half period lasts `HALF` system clocks. `done` pulses once every byte has been taken and chip select is high again.

Top module: `dual_read_engine`

## Requirements
- R1: After reset and whenever the engine is idle, cs_n is high and sclk is low. A start pulse with a nonzero byte_cnt, sampled while idle, drives cs_n low on the next cycle. SCLK is low when cs_n falls, and the first rising edge of SCLK comes 2*HALF cycles after the start edge.
- R2: While cs_n is low, io0 drives the opcode 0x3B followed by the 8*ADDR_BYTES address bits, most significant bit first, with io0_oe high. io0 changes only on a falling edge of SCLK, so it is stable at every rising edge.
- R3: The eight SCLK clocks that follow the address are dummy clocks. During them io0_oe and io1_oe are both low. io1_oe is never asserted.
- R4: Each data byte takes four SCLK rising edges. At each edge io1 supplies the higher bit of the pair and io0 the lower one (io1 carries bits 7,5,3,1 and io0 carries bits 6,4,2,0). Exactly byte_cnt bytes are delivered, in the order received.
- R5: rx_dual, the receiver's two-line mode flag, rises at the start of the data phase and clears when cs_n rises. It is low at all other times.
- R6: No byte reaches the receive stream during the command, address or dummy clocks. rx_valid stays low while io0_oe is high.
- R7: A byte moves on each edge where rx_valid and rx_ready are both high. While rx_valid is high and rx_ready is low, rx_valid and rx_data hold their values.
- R8: The FIFO holds at most FIFO_DEPTH bytes. When it is full at a byte boundary, SCLK stays low with cs_n low until a byte is taken. No byte is lost or repeated.
- R9: After the last data rising edge, SCLK goes low and cs_n stays low for one more SCLK period. Without back-pressure, cs_n rises 2*HALF*(16+8*ADDR_BYTES+4*byte_cnt)+3*HALF cycles after the start edge.
- R10: done is a one-cycle pulse. It comes while cs_n is high, one cycle after cs_n rises if the FIFO is already empty, and otherwise one cycle after the host takes the last byte. The engine is then idle.
- R11: A start pulse during a transaction is ignored, and so is a start pulse with byte_cnt of zero; cs_n stays high for the latter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a read (sampled when idle) |
| addr | input | 8*ADDR_BYTES | Flash byte address |
| byte_cnt | input | CNT_W | Number of bytes to read |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | rx_data holds a byte |
| rx_ready | input | 1 | Host accepts the byte |
| done | output | 1 | Transaction finished pulse |
| rx_dual | output | 1 | Receiver in two-line mode |
| sclk | output | 1 | Flash serial clock |
| cs_n | output | 1 | Flash chip select, active low |
| io0_o | output | 1 | IO0 output value |
| io0_oe | output | 1 | IO0 output enable |
| io0_i | input | 1 | IO0 input value |
| io1_o | output | 1 | IO1 output value |
| io1_oe | output | 1 | IO1 output enable |
| io1_i | input | 1 | IO1 input value |

## Verification
The bench counts clock cycles from the edge that accepts start. cs_n must be low one cycle later. The first SCLK rise is due at 2*HALF cycles. Without back-pressure, the cs_n rise is due at exactly 2*HALF*(16+8*ADDR_BYTES+4*byte_cnt)+3*HALF cycles, and done one cycle after that. Each of these is compared at that cycle count, with outputs sampled on the falling clock edge. A behavioural flash in the bench captures the command on SCLK rises and launches data pairs on SCLK falls, so every byte value and the bit order are checked against what the flash sent. A run with a withheld ready checks that SCLK is frozen low by a fixed cycle, and that the head byte holds still while the stream waits.

// File: rtl/dre_pkg.sv
package dre_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_CMD, ST_DUMMY, ST_DATA, ST_HOLD, ST_DRAIN, ST_DONE
  } dre_state_e;

  localparam logic [7:0] DUAL_READ_OP = 8'h3B;
  localparam int         DUMMY_CLKS   = 8;
endpackage

// File: rtl/dre_tick.sv
// Half-period timer: ticks every HALF cycles while run is high;
// a stall freezes it at the expiry point.
module dre_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic stall,
  output logic tick
);
  localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(HALF - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= RELOAD;
    else if (!run)           cnt <= RELOAD;
    else if (cnt == '0) begin
      if (!stall)            cnt <= RELOAD;
    end
    else                     cnt <= cnt - 1'b1;
  end

  assign tick = run && (cnt == '0) && !stall;
endmodule

// File: rtl/dre_deser.sv
// Byte assembler: two bits per sample in dual mode (io1 high bit),
// one bit per sample from io1 otherwise.
module dre_deser (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dual,
  input  logic       clear,
  input  logic       sample,
  input  logic       io0,
  input  logic       io1,
  output logic [7:0] byte_o,
  output logic       byte_stb,
  output logic       at_start
);
  logic [6:0] acc;
  logic [2:0] idx;
  logic       last;

  assign last = dual ? (idx == 3'd3) : (idx == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      idx <= '0;
    end else if (clear) begin
      idx <= '0;
    end else if (sample) begin
      acc <= dual ? {acc[4:0], io1, io0} : {acc[5:0], io1};
      idx <= last ? 3'd0 : idx + 3'd1;
    end
  end

  assign byte_stb = sample && last && !clear;
  assign byte_o   = dual ? {acc[5:0], io1, io0} : {acc[6:0], io1};
  assign at_start = (idx == 3'd0);
endmodule

// File: rtl/dre_fifo.sv
module dre_fifo #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] din,
  output logic       full,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [7:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign full     = (cnt == (AW+1)'(DEPTH));
  assign rx_valid = (cnt != '0);
  assign rx_data  = mem[rp];
  assign do_push  = push && !full;
  assign do_pop   = rx_valid && rx_ready;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/dual_read_engine.sv
module dual_read_engine
  import dre_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int CNT_W      = 16,
  parameter int HALF       = 2,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [8*ADDR_BYTES-1:0] addr,
  input  logic [CNT_W-1:0]        byte_cnt,
  output logic [7:0]              rx_data,
  output logic                    rx_valid,
  input  logic                    rx_ready,
  output logic                    done,
  output logic                    rx_dual,
  output logic                    sclk,
  output logic                    cs_n,
  output logic                    io0_o,
  output logic                    io0_oe,
  input  logic                    io0_i,
  output logic                    io1_o,
  output logic                    io1_oe,
  input  logic                    io1_i
);
  localparam int AW = 8 * ADDR_BYTES;
  localparam int SW = 8 + AW;
  localparam int BW = $clog2(SW);
  localparam logic [BW-1:0] SW_LAST    = BW'(SW - 1);
  localparam logic [BW-1:0] DUMMY_LAST = BW'(DUMMY_CLKS - 1);

  dre_state_e      state;
  logic [SW-1:0]   sh;
  logic [BW-1:0]   bitc;
  logic [CNT_W-1:0] remain;
  logic            hflag;
  logic            run, stall, tick, sample;
  logic            fifo_full, byte_stb, at_start;
  logic [7:0]      rx_byte;

  assign run    = (state == ST_SETUP) || (state == ST_CMD) || (state == ST_DUMMY)
               || (state == ST_DATA)  || (state == ST_HOLD);
  assign stall  = (state == ST_DATA) && !sclk && at_start && fifo_full;
  assign sample = tick && (state == ST_DATA) && !sclk;

  dre_tick #(.HALF(HALF)) tick_i (
    .clk(clk), .rst_n(rst_n), .run(run), .stall(stall), .tick(tick)
  );

  dre_deser deser_i (
    .clk(clk), .rst_n(rst_n), .dual(rx_dual), .clear(state == ST_IDLE),
    .sample(sample), .io0(io0_i), .io1(io1_i),
    .byte_o(rx_byte), .byte_stb(byte_stb), .at_start(at_start)
  );

  dre_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(byte_stb), .din(rx_byte), .full(fifo_full),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sh      <= '0;
      bitc    <= '0;
      remain  <= '0;
      hflag   <= 1'b0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      rx_dual <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          sclk <= 1'b0;
          if (start && byte_cnt != '0) begin
            sh     <= {DUAL_READ_OP, addr};
            remain <= byte_cnt;
            cs_n   <= 1'b0;
            state  <= ST_SETUP;
          end
        end
        ST_SETUP: if (tick) begin
          bitc  <= '0;
          state <= ST_CMD;
        end
        ST_CMD: if (tick) begin
          if (!sclk) sclk <= 1'b1;
          else begin
            sclk <= 1'b0;
            if (bitc == SW_LAST) begin
              bitc  <= '0;
              state <= ST_DUMMY;
            end else begin
              bitc <= bitc + 1'b1;
              sh   <= sh << 1;
            end
          end
        end
        ST_DUMMY: if (tick) begin
          if (!sclk) sclk <= 1'b1;
          else begin
            sclk <= 1'b0;
            if (bitc == DUMMY_LAST) begin
              rx_dual <= 1'b1;
              state   <= ST_DATA;
            end else bitc <= bitc + 1'b1;
          end
        end
        ST_DATA: if (tick) begin
          if (!sclk) begin
            sclk <= 1'b1;
            if (byte_stb) remain <= remain - 1'b1;
          end else begin
            sclk <= 1'b0;
            if (remain == '0) begin
              hflag <= 1'b0;
              state <= ST_HOLD;
            end
          end
        end
        ST_HOLD: if (tick) begin
          if (hflag) begin
            cs_n    <= 1'b1;
            rx_dual <= 1'b0;
            state   <= ST_DRAIN;
          end else hflag <= 1'b1;
        end
        ST_DRAIN: if (!rx_valid) state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign done   = (state == ST_DONE);
  assign io0_o  = sh[SW-1];
  assign io0_oe = (state == ST_SETUP) || (state == ST_CMD);
  assign io1_o  = 1'b0;
  assign io1_oe = 1'b0;
endmodule

// File: rtl/dual_read_engine_chk.sv
module dual_read_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       cs_n,
  input logic       io0_o,
  input logic       io0_oe,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       done,
  input logic       rx_dual
);
  // R1
  cs_fall_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sclk);

  // R2
  io0_launch_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && io0_oe && (io0_o != $past(io0_o))) |-> (!sclk && $past(sclk)));

  // R5
  dual_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dual |-> !cs_n);

  // R6
  no_rx_during_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io0_oe |-> !rx_valid);

  // R7
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R10
  done_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind dual_read_engine dual_read_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .io0_o(io0_o),
  .io0_oe(io0_oe), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .done(done), .rx_dual(rx_dual)
);

// File: tb/dual_read_engine_tb_top.sv
`timescale 1ns/1ps
module dual_read_engine_tb_top;
  localparam int AB    = 3;
  localparam int HALF  = 2;
  localparam int DEPTH = 4;
  localparam int TXB   = 8 + 8*AB;
  localparam int PRE   = TXB + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [8*AB-1:0] addr = '0;
  logic [15:0] byte_cnt = '0;
  logic rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic rx_valid, done, rx_dual, sclk, cs_n, io0_o, io0_oe, io1_o, io1_oe;
  logic io0_i, io1_i;

  always #4 clk = ~clk;

  dual_read_engine #(.ADDR_BYTES(AB), .CNT_W(16), .HALF(HALF), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .byte_cnt(byte_cnt),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .done(done),
    .rx_dual(rx_dual), .sclk(sclk), .cs_n(cs_n), .io0_o(io0_o), .io0_oe(io0_oe),
    .io0_i(io0_i), .io1_o(io1_o), .io1_oe(io1_oe), .io1_i(io1_i)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // ---------------- behavioural flash ----------------
  logic [7:0] pat_seed = 8'h00;
  function automatic logic [7:0] pat(input int k);
    return pat_seed ^ 8'(k * 29);
  endfunction

  logic fl_io0 = 1'b0, fl_io1 = 1'b0, fl_oe = 1'b0;
  logic [TXB-1:0] fl_cmd = '0;
  int fl_bits = 0;
  int dummy_bad = 0, tx_oe_bad = 0, contention = 0, io1_drv = 0;
  int r2_bad = 0, dual_in_tx = 0, n_cs_fall = 0;

  assign io0_i = io0_oe ? io0_o : fl_io0;
  assign io1_i = fl_io1;

  always @(negedge cs_n) begin
    fl_bits = 0;
    fl_cmd  = '0;
    fl_oe   = 1'b0;
    n_cs_fall++;
  end
  always @(posedge cs_n) fl_oe = 1'b0;

  always @(posedge sclk) if (!cs_n) begin
    if (fl_bits < TXB) begin
      fl_cmd = {fl_cmd[TXB-2:0], io0_o};
      if (!io0_oe) tx_oe_bad++;
    end else if (fl_bits < PRE) begin
      if (io0_oe || io1_oe) dummy_bad++;
    end
    fl_bits++;
  end

  always @(negedge sclk) if (!cs_n && fl_bits >= PRE) begin
    int k, p;
    logic [7:0] b;
    k = (fl_bits - PRE) / 4;
    p = (fl_bits - PRE) % 4;
    b = pat(k);
    fl_oe  = 1'b1;
    fl_io1 = b[7-2*p];
    fl_io0 = b[6-2*p];
  end

  logic prev_sclk = 1'b0, prev_io0 = 1'b0, prev_cs_n = 1'b1;
  always @(negedge clk) begin
    if (io0_oe && fl_oe) contention++;
    if (io1_oe) io1_drv++;
    if (rx_dual && io0_oe) dual_in_tx++;
    if (!cs_n && !prev_cs_n && io0_oe && io0_o != prev_io0 && !(prev_sclk && !sclk)) r2_bad++;
    prev_sclk = sclk;
    prev_io0  = io0_o;
    prev_cs_n = cs_n;
  end

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(cs_n == 1'b1 && sclk == 1'b0, "R1", $sformatf("reset cs_n=%0b sclk=%0b exp 1/0", cs_n, sclk));
    check(!rx_valid && !done, "R10", $sformatf("reset rx_valid=%0b done=%0b exp 0/0", rx_valid, done));
    check(!rx_dual && !io0_oe && !io1_oe, "R5", $sformatf("reset dual=%0b oe0=%0b oe1=%0b exp 0", rx_dual, io0_oe, io1_oe));
  endtask

  task automatic t_read(input logic [8*AB-1:0] a, input int n, input logic [7:0] sd,
                        input int ready_from, input int poke_cyc, input string tag);
    int cyc, got, cs_rise, done_cyc, done_hi, first_rise, sclk_hi_win, falls0;
    bit dual_ok_seen;
    logic [7:0] held;
    cyc = 0; got = 0; cs_rise = -1; done_cyc = -1; done_hi = 0; first_rise = -1;
    sclk_hi_win = 0; dual_ok_seen = 0; held = 8'h00;
    pat_seed = sd;
    dummy_bad = 0; tx_oe_bad = 0; contention = 0; io1_drv = 0; r2_bad = 0; dual_in_tx = 0;
    falls0 = n_cs_fall;
    @(negedge clk);
    addr = a; byte_cnt = 16'(n); start = 1'b1; rx_ready = (ready_from == 0);
    @(negedge clk);
    start = 1'b0;
    check(cs_n == 1'b0, "R1", $sformatf("%s cs_n one cycle after start=%0b exp 0", tag, cs_n));
    while ((done_cyc < 0 || cyc < done_cyc + 3) && cyc < 20000) begin
      if (cyc == poke_cyc) begin
        start = 1'b1; addr = ~a; byte_cnt = 16'(n + 5);
      end else start = 1'b0;
      rx_ready = (cyc >= ready_from);
      if (sclk && first_rise < 0) first_rise = cyc;
      if (ready_from > 0 && cyc >= 230 && cyc < ready_from && sclk) sclk_hi_win++;
      if (ready_from > 0 && cyc == 232) held = rx_data;
      if (ready_from > 0 && cyc == ready_from - 1) begin
        check(rx_valid && rx_data == held && rx_data == pat(0), "R7",
              $sformatf("%s stalled head %0h held %0h exp %0h", tag, rx_data, held, pat(0)));
        check(!cs_n == 1'b1 && !sclk, "R8",
              $sformatf("%s full fifo cs_n=%0b sclk=%0b exp 0/0", tag, cs_n, sclk));
      end
      if (rx_valid && rx_dual && !dual_ok_seen) dual_ok_seen = 1;
      if (rx_valid && rx_ready) begin
        if (rx_data != pat(got))
          check(0, "R4", $sformatf("%s byte %0d got %0h exp %0h", tag, got, rx_data, pat(got)));
        got++;
      end
      if (cs_n && cs_rise < 0) cs_rise = cyc;
      if (done) begin
        done_hi++;
        if (done_cyc < 0) done_cyc = cyc;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(first_rise == 2*HALF, "R1", $sformatf("%s first sclk rise at %0d exp %0d", tag, first_rise, 2*HALF));
    check(fl_cmd == {8'h3B, a}, "R2", $sformatf("%s command %0h exp %0h", tag, fl_cmd, {8'h3B, a}));
    check(tx_oe_bad == 0 && r2_bad == 0, "R2", $sformatf("%s oe miss %0d launch err %0d exp 0/0", tag, tx_oe_bad, r2_bad));
    check(dummy_bad == 0 && io1_drv == 0 && contention == 0, "R3",
          $sformatf("%s dummy drive %0d io1 drive %0d clash %0d exp 0", tag, dummy_bad, io1_drv, contention));
    check(got == n && fl_bits == PRE + 4*n, "R4", $sformatf("%s bytes %0d clocks %0d exp %0d/%0d", tag, got, fl_bits, n, PRE + 4*n));
    check(dual_ok_seen && !rx_dual && dual_in_tx == 0, "R5",
          $sformatf("%s dual in data=%0b after=%0b in tx=%0d exp 1/0/0", tag, dual_ok_seen, rx_dual, dual_in_tx));
    check(dual_in_tx == 0, "R6", $sformatf("%s tx-phase overlap %0d exp 0", tag, dual_in_tx));
    if (ready_from == 0) begin
      check(cs_rise == 2*HALF*(PRE + 4*n) + 3*HALF, "R9",
            $sformatf("%s cs_n rise at %0d exp %0d", tag, cs_rise, 2*HALF*(PRE + 4*n) + 3*HALF));
      check(done_cyc == cs_rise + 1 && done_hi == 1, "R10",
            $sformatf("%s done at %0d width %0d exp %0d/1", tag, done_cyc, done_hi, cs_rise + 1));
    end else begin
      check(sclk_hi_win == 0, "R8", $sformatf("%s sclk high cycles while full %0d exp 0", tag, sclk_hi_win));
      check(cs_rise > 2*HALF*(PRE + 4*n) + 3*HALF && done_hi == 1 && done_cyc > cs_rise, "R10",
            $sformatf("%s cs rise %0d done %0d width %0d", tag, cs_rise, done_cyc, done_hi));
    end
    check(n_cs_fall - falls0 == 1 && cs_n, "R11",
          $sformatf("%s transactions %0d exp 1, cs_n=%0b", tag, n_cs_fall - falls0, cs_n));
  endtask

  task automatic t_zero();
    int falls0;
    int bad;
    falls0 = n_cs_fall;
    bad = 0;
    @(negedge clk);
    addr = 24'h123456; byte_cnt = 16'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (!cs_n || done || sclk) bad++;
      @(negedge clk);
    end
    check(bad == 0 && n_cs_fall == falls0, "R11",
          $sformatf("zero count activity %0d falls %0d exp 0/0", bad, n_cs_fall - falls0));
  endtask

  initial begin
    #1200000;
    check(0, "WATCHDOG", "run did not finish, exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_read(24'hA5C30F, 1, 8'h6E, 0, -1, "single");
    t_read(24'h00FF81, 5, 8'hB1, 0, -1, "five");
    t_read(24'h3C0001, 9, 8'h27, 300, -1, "stall");
    t_read(24'h800040, 2, 8'hD4, 0, 50, "poke");
    t_zero();
    finish_run();
  end
endmodule